// File: doc/BRIEF.md
# Ramp Converter Trim Calibration Sequencer

This block tunes the trim code of a current source that sets the slope of a ramp-type converter. A larger trim code gives a steeper ramp, so the converter's reading of a fixed internal reference falls as the trim rises. When a start strobe arrives, the block captures a target count and clears the trim code. The target is the converter's maximum count scaled by the ratio of the reference voltage to the ideal peak ramp voltage, which is five sevenths. The block then switches the converter input to the calibration channel and starts a loop.

In each pass of the loop the block issues a single-cycle conversion request and waits for a result-valid pulse. If the result is greater than the target, it steps the trim code up by one and requests again. If the result is at or below the target, it stops and keeps the trim code it has. If the trim code has reached all ones and the result is still too high, it stops and reports saturation. The done flag stays high until the next start.

Top module: `ramp_trim_cal`

## Requirements
- R1: After reset the trim code is 0, and busy, done, saturation error, conversion request and channel select are all low.
- R2: On an accepted start, the target is captured as floor(max_count × 5 / 7), using the value of max_count in the start cycle.
- R3: An accepted start clears the trim code to 0 and clears done and the saturation error in the following cycle.
- R4: The channel select output goes high in the cycle after an accepted start. This is one cycle before the first conversion request. It stays high until the sequence ends and is low at all other times.
- R5: A valid result strictly greater than the target, with the trim code below all ones, raises the trim code by exactly one. A new request follows in the next cycle.
- R6: Each conversion request is high for exactly one cycle. The next step waits for the result-valid pulse. A result-valid pulse that arrives while no result is awaited has no effect.
- R7: A valid result less than or equal to the target ends the sequence with the trim code unchanged. Done then stays high until the next accepted start.
- R8: Busy is high from the cycle after an accepted start through the cycle in which the final result arrives. Busy and done are never high together. A start strobe that arrives while busy is ignored.
- R9: If the trim code is all ones and the valid result is still greater than the target, the sequence stops with the trim code held at all ones. The saturation error is raised together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| max_count_i | input | CNT_W | Converter full-scale count |
| conv_data_i | input | CNT_W | Conversion result |
| conv_valid_i | input | 1 | Result-valid pulse |
| trim_o | output | TRIM_W | Current-source trim code |
| conv_req_o | output | 1 | Conversion request pulse |
| cal_sel_o | output | 1 | Selects the calibration channel on the converter input |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished, held until next start |
| sat_err_o | output | 1 | Trim code ran out before the exit condition was met |

## Verification
The bench builds the block with CNT_W = 12 and TRIM_W = 4. A 4-bit trim code saturates after sixteen conversions, so the all-ones stop path is reached within a few hundred cycles. A 12-bit count lets the integer 5/7 target land at both 2925 (full scale) and 500 (max_count 700), so exact-equality exits are reached at both values. The bench's converter model returns a reading that falls linearly with the trim code, with latencies of one to several cycles. This covers immediate exit, multi-step convergence, equality exit, saturation, stray valid pulses and a start strobe injected mid-sequence.

// File: rtl/ramp_trim_cal_pkg.sv
package ramp_trim_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_DONE = 3'd4
  } cal_state_t;

  localparam int unsigned RATIO_NUM = 5;
  localparam int unsigned RATIO_DEN = 7;

endpackage

// File: rtl/cal_target_calc.sv
module cal_target_calc
  import ramp_trim_cal_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] max_count_i,
  input  logic [CNT_W-1:0] result_i,
  output logic             res_gt_o
);

  localparam int unsigned PROD_W = CNT_W + 3;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [CNT_W-1:0]  tgt_d;
  logic [CNT_W-1:0]  tgt_q;

  always_comb begin
    prod  = PROD_W'(max_count_i) * PROD_W'(RATIO_NUM);
    quot  = prod / PROD_W'(RATIO_DEN);
    tgt_d = quot[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (load_i) begin
      tgt_q <= tgt_d;
    end
  end

  assign res_gt_o = (result_i > tgt_q);

  p_target_scaled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tgt_q <= $past(max_count_i)));

endmodule

// File: rtl/cal_trim_reg.sv
module cal_trim_reg #(
  parameter int unsigned TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              at_max_o
);

  logic [TRIM_W-1:0] trim_d;
  logic [TRIM_W-1:0] trim_q;
  logic              trim_en;

  always_comb begin
    trim_en = clr_i | inc_i;
    if (clr_i) begin
      trim_d = '0;
    end else begin
      trim_d = trim_q + TRIM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
    end else if (trim_en) begin
      trim_q <= trim_d;
    end
  end

  assign trim_o   = trim_q;
  assign at_max_o = &trim_q;

  p_trim_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim_q) |-> (trim_q == '0 || trim_q == $past(trim_q) + TRIM_W'(1)));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trim_q) == '1 && !$past(clr_i)) |-> (trim_q == '1));

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import ramp_trim_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  input  logic res_gt_i,
  input  logic at_max_i,
  output logic load_o,
  output logic clr_o,
  output logic inc_o,
  output logic req_o,
  output logic sel_o,
  output logic busy_o,
  output logic done_o,
  output logic sat_o
);

  cal_state_t st_q, st_d;
  logic       sat_q, sat_d;
  logic       sat_en;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    clr_o  = 1'b0;
    inc_o  = 1'b0;
    sat_en = 1'b0;
    sat_d  = sat_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d   = ST_SEL;
          load_o = 1'b1;
          clr_o  = 1'b1;
          sat_en = 1'b1;
          sat_d  = 1'b0;
        end
      end
      ST_SEL:  st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (valid_i) begin
          if (!res_gt_i) begin
            st_d = ST_DONE;
          end else if (at_max_i) begin
            st_d   = ST_DONE;
            sat_en = 1'b1;
            sat_d  = 1'b1;
          end else begin
            st_d  = ST_REQ;
            inc_o = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
    end else if (sat_en) begin
      sat_q <= sat_d;
    end
  end

  assign req_o  = (st_q == ST_REQ);
  assign busy_o = (st_q == ST_SEL) || (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign sel_o  = busy_o;
  assign done_o = (st_q == ST_DONE);
  assign sat_o  = sat_q;

  p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  p_sel_leads_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(sel_o));

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_done_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/ramp_trim_cal.sv
module ramp_trim_cal
  import ramp_trim_cal_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  max_count_i,
  input  logic [CNT_W-1:0]  conv_data_i,
  input  logic              conv_valid_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              conv_req_o,
  output logic              cal_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sat_err_o
);

  logic load_w, clr_w, inc_w, gt_w, at_max_w;

  cal_target_calc #(.CNT_W(CNT_W)) u_tgt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .max_count_i (max_count_i),
    .result_i    (conv_data_i),
    .res_gt_o    (gt_w)
  );

  cal_trim_reg #(.TRIM_W(TRIM_W)) u_trim (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_w),
    .inc_i    (inc_w),
    .trim_o   (trim_o),
    .at_max_o (at_max_w)
  );

  cal_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .valid_i  (conv_valid_i),
    .res_gt_i (gt_w),
    .at_max_i (at_max_w),
    .load_o   (load_w),
    .clr_o    (clr_w),
    .inc_o    (inc_w),
    .req_o    (conv_req_o),
    .sel_o    (cal_sel_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sat_o    (sat_err_o)
  );

  p_sat_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err_o |-> (done_o && trim_o == '1));

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (trim_o == '0 && !done_o && !sat_err_o));

endmodule

// File: tb/ramp_trim_cal_tb.sv
module ramp_trim_cal_tb;

  localparam int CNT_W  = 12;
  localparam int TRIM_W = 4;
  localparam int TMAX   = (1 << TRIM_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [CNT_W-1:0]  max_count_i;
  logic [CNT_W-1:0]  conv_data_i;
  logic              conv_valid_i;
  logic [TRIM_W-1:0] trim_o;
  logic              conv_req_o, cal_sel_o, busy_o, done_o, sat_err_o;

  ramp_trim_cal #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_count_i(max_count_i),
    .conv_data_i(conv_data_i), .conv_valid_i(conv_valid_i), .trim_o(trim_o),
    .conv_req_o(conv_req_o), .cal_sel_o(cal_sel_o), .busy_o(busy_o),
    .done_o(done_o), .sat_err_o(sat_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // converter model parameters
  int cv_base = 0, cv_step = 0, cv_lat = 1;
  bit stray = 0;

  // reference model state: 0 idle, 1 select, 2 request, 3 wait, 4 done
  int m_ph = 0, m_trim = 0, m_tgt = 0;
  bit m_sat = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each clock edge from the bench's inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_trim = 0; m_tgt = 0; m_sat = 0;
    end else begin
      cyc++;
      case (m_ph)
        0, 4: if (start_i) begin
          m_tgt = (int'(max_count_i) * 5) / 7; m_trim = 0; m_sat = 0; m_ph = 1;
        end
        1: m_ph = 2;
        2: m_ph = 3;
        3: if (conv_valid_i) begin
          if (int'(conv_data_i) <= m_tgt) m_ph = 4;
          else if (m_trim == TMAX) begin m_ph = 4; m_sat = 1; end
          else begin m_trim++; m_ph = 2; end
        end
        default: m_ph = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(trim_o) == m_trim, "R5 trim", trim_o, m_trim);
      chk(conv_req_o == (m_ph == 2), "R6 req", conv_req_o, m_ph == 2);
      chk(cal_sel_o == (m_ph >= 1 && m_ph <= 3), "R4 sel", cal_sel_o, m_ph >= 1 && m_ph <= 3);
      chk(busy_o == (m_ph >= 1 && m_ph <= 3), "R8 busy", busy_o, m_ph >= 1 && m_ph <= 3);
      chk(done_o == (m_ph == 4), "R7 done", done_o, m_ph == 4);
      chk(sat_err_o == m_sat, "R9 sat", sat_err_o, m_sat);
    end
  end

  // converter responder: linear falling reading, fixed latency
  int cd = 0;
  int pend = 0;
  always @(negedge clk) begin
    conv_valid_i = 1'b0;
    if (cd == 1) begin
      conv_valid_i = 1'b1; conv_data_i = CNT_W'(pend); cd = 0;
    end else if (cd > 1) begin
      cd--;
    end else if (stray) begin
      conv_valid_i = 1'b1; conv_data_i = '0;
    end
    if (conv_req_o) begin
      pend = cv_base - int'(trim_o) * cv_step;
      if (pend < 0) pend = 0;
      cd = cv_lat;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // independent expectation of the final trim code
  task automatic run_cal(input int maxc, input int base, input int step, input int lat,
                         input string tag);
    int tgt, k, guard;
    bit sat;
    cv_base = base; cv_step = step; cv_lat = lat; max_count_i = CNT_W'(maxc);
    tgt = (maxc * 5) / 7;
    k = 0; sat = 0;
    while (base - k * step > tgt) begin
      if (k == TMAX) begin sat = 1; break; end
      k++;
    end
    pulse_start();
    guard = 0;
    while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
    chk(done_o, {tag, " done reached"}, done_o, 1);
    chk(int'(trim_o) == k, {tag, " final trim"}, trim_o, k);
    chk(sat_err_o == sat, {tag, " saturation"}, sat_err_o, sat);
    repeat (3) @(negedge clk);
    chk(done_o && int'(trim_o) == k, "R7 done and trim held", trim_o, k);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    report();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; max_count_i = '0; conv_data_i = '0;
    repeat (3) @(negedge clk);
    chk(trim_o == '0 && !busy_o && !done_o && !sat_err_o && !conv_req_o && !cal_sel_o,
        "R1 reset state", {trim_o, busy_o, done_o, sat_err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: stray valid pulses while idle have no effect
    stray = 1; repeat (4) @(negedge clk); stray = 0;
    chk(!busy_o && !done_o && trim_o == '0, "R6 stray valid idle", trim_o, 0);

    run_cal(4095, 2000, 20, 1, "R7 immediate exit");          // trim 0
    run_cal(4095, 3100, 20, 1, "R5 multi-step");              // target 2925, trim 9
    run_cal(4095, 2985, 20, 3, "R7 equal exit");              // equality at trim 3
    run_cal(700, 510, 5, 2, "R2 small target");               // target 500, trim 2
    run_cal(4095, 4000, 10, 1, "R9 saturation");              // trim 15, sat

    // R3: restart after saturation clears flags and trim
    max_count_i = 12'd4095; cv_base = 2500; cv_step = 1; cv_lat = 6;
    pulse_start();
    chk(trim_o == '0 && !sat_err_o && !done_o, "R3 clear on start", trim_o, 0);
    // R8: start during busy ignored, target must stay from first start
    repeat (2) @(negedge clk);
    max_count_i = 12'd100;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R8 start while busy ignored", busy_o, 1);
    // R6: stray valid while waiting is the awaited result; after done, stray ignored
    while (!done_o) @(negedge clk);
    chk(int'(trim_o) == 0, "R2 target kept from accepted start", trim_o, 0);
    stray = 1; repeat (3) @(negedge clk); stray = 0;
    chk(done_o && trim_o == '0, "R6 stray valid after done", trim_o, 0);

    repeat (4) @(negedge clk);
    report();
  end

endmodule